// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits in front of the nonvolatile bank of a memory subsystem. It watches the write cycles that reach that bank and matches them against fixed multi-write unlock sequences. Each write cycle carries an address and a data byte. When a complete, well-formed sequence arrives, the block issues an operation request: a byte program with its target address and data, a sector erase with a sector number, or a bank erase. A separate sequence enters identification mode, and while that mode is active, reads at the lowest two addresses return a manufacturer byte and a device byte.

The write stream is qualified by a busy flag from the bank's internal timing engine. While that flag is high, every write is dropped. The sequence position and the identification mode do not change. A write that does not match the step the decoder is waiting for sends it back to its idle state. Such a write does not count as the start of a new sequence. The array and the status reporting sit outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: When an address is compared during a command step, only bits 14:0 are used, and bits 18:15 may hold any value. A write whose bits 14:0 differ from the expected key does not match.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by one more write, produce a program request. `prog_req_o` is high for exactly the one cycle after that fourth write, with `prog_addr_o`/`prog_data_o` equal to the fourth write's full address and data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 30h at any address, raise `sect_erase_req_o` for the cycle after the sixth write. `sect_num_o` equals bits 18:12 of that sixth write's address.
- R4: The same five-write prefix, followed by 10h@5555h, raises `bank_erase_req_o` for one cycle. A 10h at any other address aborts the sequence.
- R5: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode_o` in the cycle after the third write. In ID mode, `id_data_o` is MFR_CODE (default BFh) for `rd_addr_i`=0, DEV_CODE for `rd_addr_i`=1, and 00h for any other address. Outside ID mode, `id_data_o` is 00h.
- R6: ID mode is cleared by AAh@5555h, 55h@2AAAh, F0h@5555h. It is also cleared by a single F0h at any address written while the decoder is idle.
- R7: A write that does not match the expected step returns the decoder to idle and does not itself start a new sequence. An abort leaves `id_mode_o` unchanged.
- R8: A write presented with `busy_i` high is ignored. It issues no request and leaves both the sequence position and `id_mode_o` unchanged, so a sequence can continue across such writes.
- R9: At most one request output is high in any cycle, and each request lasts one cycle.
- R10: After reset, no request is active, `id_mode_o` is low, and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write cycle to the nonvolatile bank |
| busy_i | input | 1 | Internal program or erase in progress |
| addr_i | input | 19 | Write address |
| data_i | input | 8 | Write data |
| rd_addr_i | input | 19 | Read address for ID bytes |
| prog_req_o | output | 1 | One-cycle byte program request |
| prog_addr_o | output | 19 | Program target address |
| prog_data_o | output | 8 | Program data |
| sect_erase_req_o | output | 1 | One-cycle sector erase request |
| sect_num_o | output | 7 | Sector number to erase |
| bank_erase_req_o | output | 1 | One-cycle bank erase request |
| id_mode_o | output | 1 | ID mode active |
| id_data_o | output | 8 | ID byte for rd_addr_i |

## Verification
Every request pulse and every change of `id_mode_o` comes from a register that is loaded on the edge that samples the completing write. It therefore appears one cycle after that write, and `id_data_o` follows `rd_addr_i` combinationally in the same cycle. The bench applies inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output against that model on the next falling edge, which is exactly where each one-cycle-late result is due. Request fields are compared only in the cycles where the model expects a request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } seq_state_e;

  localparam logic [BYTE_W-1:0] CD_KEY_A    = 8'hAA;
  localparam logic [BYTE_W-1:0] CD_KEY_B    = 8'h55;
  localparam logic [BYTE_W-1:0] CD_PROG     = 8'hA0;
  localparam logic [BYTE_W-1:0] CD_ERASE    = 8'h80;
  localparam logic [BYTE_W-1:0] CD_ID_ENTER = 8'h90;
  localparam logic [BYTE_W-1:0] CD_ID_EXIT  = 8'hF0;
  localparam logic [BYTE_W-1:0] CD_SECT     = 8'h30;
  localparam logic [BYTE_W-1:0] CD_BANK     = 8'h10;

  typedef struct packed {
    logic hit_a;
    logic hit_b;
  } addr_hit_t;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CMP_W = 15,
  parameter logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic [CMP_W-1:0] addr_lo_i,
  output addr_hit_t        hit_o
);
  logic [CMP_W-1:0] diff_a, diff_b;

  for (genvar b = 0; b < CMP_W; b++) begin : g_bit
    assign diff_a[b] = addr_lo_i[b] ^ KEY_ADDR_A[b];
    assign diff_b[b] = addr_lo_i[b] ^ KEY_ADDR_B[b];
  end

  assign hit_o.hit_a = ~|diff_a;
  assign hit_o.hit_b = ~|diff_b;
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned SECT_LSB = 12,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  addr_hit_t         hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              id_set_o,
  output logic              id_clr_o,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [BYTE_W-1:0] prog_data_o,
  output logic              sect_req_o,
  output logic [SECT_W-1:0] sect_num_o,
  output logic              bank_req_o
);
  seq_state_e st_q, st_d;
  logic prog_d, sect_d, bank_d;
  logic prog_q, sect_q, bank_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [BYTE_W-1:0] pdata_q;
  logic [SECT_W-1:0] snum_q;

  always_comb begin
    st_d     = st_q;
    id_set_o = 1'b0;
    id_clr_o = 1'b0;
    prog_d   = 1'b0;
    sect_d   = 1'b0;
    bank_d   = 1'b0;
    if (acc_i) begin
      // default on any accepted write: back to idle (abort or completion)
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: begin
          if (hit_i.hit_a && data_i == CD_KEY_A) st_d = ST_UNL1;
          else if (data_i == CD_ID_EXIT)         id_clr_o = 1'b1;
        end
        ST_UNL1: if (hit_i.hit_b && data_i == CD_KEY_B) st_d = ST_UNL2;
        ST_UNL2: begin
          if (hit_i.hit_a) begin
            unique case (data_i)
              CD_PROG:     st_d = ST_PROG;
              CD_ERASE:    st_d = ST_ERS1;
              CD_ID_ENTER: id_set_o = 1'b1;
              CD_ID_EXIT:  id_clr_o = 1'b1;
              default:     st_d = ST_IDLE;
            endcase
          end
        end
        ST_PROG: prog_d = 1'b1;
        ST_ERS1: if (hit_i.hit_a && data_i == CD_KEY_A) st_d = ST_ERS2;
        ST_ERS2: if (hit_i.hit_b && data_i == CD_KEY_B) st_d = ST_ERS3;
        ST_ERS3: begin
          if (data_i == CD_SECT)                    sect_d = 1'b1;
          else if (hit_i.hit_a && data_i == CD_BANK) bank_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      prog_q  <= 1'b0;
      sect_q  <= 1'b0;
      bank_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      snum_q  <= '0;
    end else begin
      st_q   <= st_d;
      prog_q <= prog_d;
      sect_q <= sect_d;
      bank_q <= bank_d;
      if (prog_d) begin
        paddr_q <= addr_i;
        pdata_q <= data_i;
      end
      if (sect_d) snum_q <= addr_i[ADDR_W-1:SECT_LSB];
    end
  end

  assign prog_req_o  = prog_q;
  assign prog_addr_o = paddr_q;
  assign prog_data_o = pdata_q;
  assign sect_req_o  = sect_q;
  assign sect_num_o  = snum_q;
  assign bank_req_o  = bank_q;

  a_r9_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_q, sect_q, bank_q}));
  a_r9_prog_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q |=> !prog_q);
  a_r8_req_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_q || sect_q || bank_q) |-> $past(acc_i));
  a_r8_hold_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(st_q));
  a_r3_sector_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_q |-> (snum_q == $past(addr_i[ADDR_W-1:SECT_LSB])));
  a_r2_prog_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q |-> (paddr_q == $past(addr_i) && pdata_q == $past(data_i)));
endmodule

// File: rtl/fcd_id_unit.sv
module fcd_id_unit
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter logic [BYTE_W-1:0] MFR_CODE = 8'hBF,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'h17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_set_i,
  input  logic              id_clr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              id_mode_o,
  output logic [BYTE_W-1:0] id_data_o
);
  logic id_q;
  logic rd_upper_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       id_q <= 1'b0;
    else if (id_set_i) id_q <= 1'b1;
    else if (id_clr_i) id_q <= 1'b0;
  end

  assign rd_upper_zero = ~|rd_addr_i[ADDR_W-1:1];

  always_comb begin
    id_data_o = '0;
    if (id_q && rd_upper_zero) id_data_o = rd_addr_i[0] ? DEV_CODE : MFR_CODE;
  end

  assign id_mode_o = id_q;

  a_r7_id_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_set_i || id_clr_i) |=> $stable(id_q));
  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_clr_i && !id_set_i) |=> !id_q);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned CMP_W    = 15,
  parameter int unsigned SECT_LSB = 12,
  parameter logic [7:0]  MFR_CODE = 8'hBF,
  parameter logic [7:0]  DEV_CODE = 8'h17,
  localparam int unsigned SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              sect_erase_req_o,
  output logic [SECT_W-1:0] sect_num_o,
  output logic              bank_erase_req_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o
);
  addr_hit_t hit;
  logic acc, id_set, id_clr;

  // busy gates everything, including ID entry and exit
  assign acc = wr_i & ~busy_i;

  fcd_addr_match #(.CMP_W(CMP_W)) i_match (
    .addr_lo_i (addr_i[CMP_W-1:0]),
    .hit_o     (hit)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .hit_i       (hit),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .id_set_o    (id_set),
    .id_clr_o    (id_clr),
    .prog_req_o  (prog_req_o),
    .prog_addr_o (prog_addr_o),
    .prog_data_o (prog_data_o),
    .sect_req_o  (sect_erase_req_o),
    .sect_num_o  (sect_num_o),
    .bank_req_o  (bank_erase_req_o)
  );

  fcd_id_unit #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_id (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_set_i  (id_set),
    .id_clr_i  (id_clr),
    .rd_addr_i (rd_addr_i),
    .id_mode_o (id_mode_o),
    .id_data_o (id_data_o)
  );

  a_r8_busy_keeps_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(id_mode_o));
  a_r8_busy_no_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_req_o || sect_erase_req_o || bank_erase_req_o));
  a_r5_quiet_outside_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> (id_data_o == 8'h00));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 19;
  localparam logic [7:0] DEV = 8'h17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0] data = '0;
  logic prog_req, sect_req, bank_req, id_mode;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data, id_data;
  logic [6:0] sect_num;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.DEV_CODE(DEV)) i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .busy_i(busy), .addr_i(addr),
    .data_i(data), .rd_addr_i(rd_addr), .prog_req_o(prog_req),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .sect_erase_req_o(sect_req), .sect_num_o(sect_num),
    .bank_erase_req_o(bank_req), .id_mode_o(id_mode), .id_data_o(id_data)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  string phase = "R10";

  // behavioural reference: step index within the command grammar
  int step;
  bit e_prog, e_sect, e_bank, e_id;
  logic [AW-1:0] e_paddr;
  logic [7:0] e_pdata;
  logic [6:0] e_snum;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step = 0; e_prog = 0; e_sect = 0; e_bank = 0; e_id = 0;
    end else begin
      bit ka, kb;
      e_prog = 0; e_sect = 0; e_bank = 0;
      ka = (addr[14:0] == 15'h5555);
      kb = (addr[14:0] == 15'h2AAA);
      if (wr && !busy) begin
        int nxt;
        nxt = 0;
        if (step == 0) begin
          if (ka && data == 8'hAA) nxt = 1;
          else if (data == 8'hF0) e_id = 0;
        end else if (step == 1) begin
          if (kb && data == 8'h55) nxt = 2;
        end else if (step == 2) begin
          if (ka && data == 8'hA0) nxt = 3;
          else if (ka && data == 8'h80) nxt = 4;
          else if (ka && data == 8'h90) e_id = 1;
          else if (ka && data == 8'hF0) e_id = 0;
        end else if (step == 3) begin
          e_prog = 1; e_paddr = addr; e_pdata = data;
        end else if (step == 4) begin
          if (ka && data == 8'hAA) nxt = 5;
        end else if (step == 5) begin
          if (kb && data == 8'h55) nxt = 6;
        end else begin
          if (data == 8'h30) begin e_sect = 1; e_snum = addr[18:12]; end
          else if (ka && data == 8'h10) e_bank = 1;
        end
        step = nxt;
      end
    end
  end

  function automatic logic [7:0] exp_rd(bit id, logic [AW-1:0] a);
    if (!id) return 8'h00;
    if (a == 0) return 8'hBF;
    if (a == 1) return DEV;
    return 8'h00;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("prog pulse", 32'(prog_req), 32'(e_prog));
    if (e_prog) begin
      chk("prog addr", 32'(prog_addr), 32'(e_paddr));
      chk("prog data", 32'(prog_data), 32'(e_pdata));
    end
    chk("sector pulse", 32'(sect_req), 32'(e_sect));
    if (e_sect) chk("sector number", 32'(sect_num), 32'(e_snum));
    chk("bank pulse", 32'(bank_req), 32'(e_bank));
    chk("id mode", 32'(id_mode), 32'(e_id));
    chk("id data", 32'(id_data), 32'(exp_rd(e_id, rd_addr)));
  endtask

  task automatic cyc(bit w, bit b, logic [AW-1:0] a, logic [7:0] d, logic [AW-1:0] ra);
    @(negedge clk);
    compare();
    wr = w; busy = b; addr = a; data = d; rd_addr = ra;
  endtask

  task automatic wrc(logic [AW-1:0] a, logic [7:0] d);
    cyc(1, 0, a, d, '0);
  endtask

  task automatic idle(logic [AW-1:0] ra = '0);
    cyc(0, 0, '0, '0, ra);
  endtask

  task automatic prefix(logic [7:0] third);
    wrc(19'h05555, 8'hAA); wrc(19'h02AAA, 8'h55); wrc(19'h05555, third);
  endtask

  task automatic erase_prefix();
    prefix(8'h80); wrc(19'h05555, 8'hAA); wrc(19'h02AAA, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL [watchdog] run did not finish: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    phase = "R10";
    idle(); idle();
    rst_n = 1'b1;
    idle(); idle(1);

    phase = "R2";
    prefix(8'hA0); wrc(19'h12345, 8'h3C); idle(); idle();

    phase = "R1";
    wrc(19'h7D555, 8'hAA); wrc(19'h7AAAA, 8'h55); wrc(19'h45555, 8'hA0);
    wrc(19'h00010, 8'h77); idle(); idle();
    wrc(19'h05554, 8'hAA); wrc(19'h02AAA, 8'h55); wrc(19'h05555, 8'hA0);
    wrc(19'h00020, 8'h66); idle(); idle();

    phase = "R3";
    erase_prefix(); wrc(19'h6B123, 8'h30); idle(); idle();
    erase_prefix(); wrc(19'h00FFF, 8'h30); idle();

    phase = "R4";
    erase_prefix(); wrc(19'h05555, 8'h10); idle(); idle();
    erase_prefix(); wrc(19'h01234, 8'h10); idle(); idle();

    phase = "R5";
    prefix(8'h90); idle(0); idle(1); idle(2); idle(19'h40000); idle(19'h40001);

    phase = "R7";
    wrc(19'h05555, 8'hAA); wrc(19'h02AAA, 8'hF0); idle(1);
    wrc(19'h05555, 8'hAA); wrc(19'h05555, 8'hAA); wrc(19'h02AAA, 8'h55);
    wrc(19'h05555, 8'hA0); wrc(19'h00100, 8'h11); idle(); idle();
    erase_prefix(); wrc(19'h05555, 8'h20); idle(0);

    phase = "R6";
    prefix(8'hF0); idle(0); idle(1);
    prefix(8'h90); idle(1);
    wrc(19'h03210, 8'hF0); idle(0); idle(1);

    phase = "R8";
    wrc(19'h05555, 8'hAA); wrc(19'h02AAA, 8'h55);
    cyc(1, 1, 19'h00000, 8'hFF, 0);
    wrc(19'h05555, 8'hA0); wrc(19'h2ABCD, 8'h5A); idle(); idle();
    cyc(1, 1, 19'h05555, 8'hAA, 0); cyc(1, 1, 19'h02AAA, 8'h55, 0);
    cyc(1, 1, 19'h05555, 8'h90, 0); idle(0); idle(1);
    prefix(8'h90); idle(0);
    cyc(1, 1, 19'h00000, 8'hF0, 1); idle(1);
    erase_prefix(); cyc(1, 1, 19'h05555, 8'h10, 0); idle(); idle();

    phase = "R9";
    wrc(19'h00000, 8'hF0); prefix(8'hA0); wrc(19'h7FFFF, 8'h00);
    idle(); idle(); idle();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule